// File: doc/BRIEF.md
# Write strobe hold-time extender

This block sits between a processor's external write bus and a slow memory-mapped peripheral. The peripheral needs write data held longer than the processor holds it. The processor's write strobe is not wired to the peripheral. Instead, the block samples the processor's active-low write strobe and a single select input. When a selected write begins, the block raises a wait request and produces its own active-low strobe for the peripheral.

The peripheral strobe lasts a fixed number of clocks. It ends on the same clock edge that withdraws the wait request. The processor then runs its cycle one clock longer, and during that clock the data stays valid after the peripheral has latched it. The block also enforces a minimum high time between two peripheral strobes. A second write that follows at once, such as the second byte of a word written as two byte writes, is held off by the wait request until that gap has passed. Writes with the select inactive are ignored.

Top module: `wr_hold_ext`

## Requirements
- R1: While reset is asserted and right after it, `wait_req` is 0 and `per_wr_n` is 1.
- R2: When the block is idle and samples `cpu_wr_n`=0 with `per_sel`=1 on a clock edge, `wait_req` is 1 after that same edge.
- R3: Each peripheral strobe holds `per_wr_n` low for exactly WAIT_CLKS clocks, and `per_wr_n` is low only while `wait_req` is 1.
- R4: `per_wr_n` returns high on the same clock edge on which `wait_req` returns low.
- R5: Between the end of one peripheral strobe and the start of the next, `per_wr_n` stays high for at least RECOVERY_CLKS clocks.
- R6: If a selected write arrives before the gap of R5 has run out, `wait_req` is raised at once and `per_wr_n` stays high until the gap ends. The gap is then exactly RECOVERY_CLKS clocks.
- R7: A write with `per_sel`=0 raises no `wait_req` and produces no peripheral strobe.
- R8: A selected write produces exactly one peripheral strobe, however long the processor keeps `cpu_wr_n` low. The block does not accept a new write until it has seen `cpu_wr_n` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| per_sel | input | 1 | Peripheral selected by the current cycle, active high |
| wait_req | output | 1 | Wait request to the processor, active high |
| per_wr_n | output | 1 | Derived write strobe to the peripheral, active low |

## Verification
The main function is tried with four input patterns:

- **Isolated selected writes.** These give the plain strobe length and show that the strobe and the wait request end together.
- **Back-to-back writes with one idle clock.** These land inside the recovery gap. They separate a deferred strobe, whose gap is exactly the recovery count, from one that starts at once.
- **Writes held low long after the wait request drops.** These show that no second strobe appears.
- **Unselected writes.** These show that nothing reaches the peripheral.

Random sequences mix all four patterns with random idle spacing and hold lengths.

// File: rtl/wr_hold_ext.sv
module wr_hold_ext #(
  parameter int WAIT_CLKS     = 3,
  parameter int RECOVERY_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_wr_n,
  input  logic per_sel,
  output logic wait_req,
  output logic per_wr_n
);
  localparam int CW = (WAIT_CLKS > 1) ? $clog2(WAIT_CLKS) : 1;
  localparam int RW = (RECOVERY_CLKS > 1) ? $clog2(RECOVERY_CLKS) : 1;

  typedef enum logic [1:0] {IDLE, STROBE, HOLD, RECOVER} st_t;
  st_t st;
  logic [CW-1:0] wcnt;
  logic [RW-1:0] rcnt;

  wire start  = !cpu_wr_n && per_sel;
  wire gap_ok = (rcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      wait_req <= 1'b0;
      per_wr_n <= 1'b1;
      wcnt     <= '0;
      rcnt     <= '0;
    end else begin
      if (st != STROBE && !gap_ok) rcnt <= rcnt - 1'b1;
      case (st)
        IDLE: if (start) begin
          wait_req <= 1'b1;
          if (gap_ok) begin
            per_wr_n <= 1'b0;
            wcnt     <= CW'(WAIT_CLKS - 1);
            st       <= STROBE;
          end else begin
            st <= RECOVER;
          end
        end
        RECOVER: if (gap_ok) begin
          per_wr_n <= 1'b0;
          wcnt     <= CW'(WAIT_CLKS - 1);
          st       <= STROBE;
        end
        STROBE: if (wcnt == '0) begin
          per_wr_n <= 1'b1;
          wait_req <= 1'b0;
          rcnt     <= RW'(RECOVERY_CLKS - 1);
          st       <= HOLD;
        end else begin
          wcnt <= wcnt - 1'b1;
        end
        HOLD: if (cpu_wr_n) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  p_reset_levels_r1: assert property (@(posedge clk)
    !rst_n |=> (per_wr_n && !wait_req));

  p_wait_on_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && start) |=> wait_req);

  p_strobe_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !per_wr_n |-> wait_req);

  p_end_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_wr_n) |-> $fell(wait_req));

  p_recover_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RECOVER) |-> (per_wr_n && wait_req));

  p_unselected_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && !per_sel) |=> (per_wr_n && !wait_req));

  p_hold_until_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && !cpu_wr_n) |=> (st == HOLD && per_wr_n));
endmodule

// File: tb/test_wr_hold_ext.sv
module test_wr_hold_ext;
  localparam int W = 3;
  localparam int R = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_n = 1'b1;
  logic per_sel = 1'b0;
  logic wait_req, per_wr_n;

  int total = 0, bad = 0, pulses = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  wr_hold_ext #(.WAIT_CLKS(W), .RECOVERY_CLKS(R)) i_wr_hold_ext (
    .clk(clk), .rst_n(rst_n), .cpu_wr_n(cpu_wr_n), .per_sel(per_sel),
    .wait_req(wait_req), .per_wr_n(per_wr_n));

  function automatic void chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endfunction

  function automatic bit gap_ok(input bit deferred, input int gap);
    return deferred ? (gap == R) : (gap >= R);
  endfunction

  // monitor: strobe length, gap, alignment with wait request
  logic prev_per = 1'b1, prev_wait = 1'b0;
  int low_len = 0, high_len = 0;
  bit seen = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_per && !per_wr_n) begin
        pulses++;
        if (seen) begin
          if (prev_wait) chk(gap_ok(1'b1, high_len), "R6 deferred gap", high_len, R);
          else           chk(gap_ok(1'b0, high_len), "R5 min gap", high_len, R);
        end
        seen = 1'b1;
        low_len = 1;
      end else if (!per_wr_n) begin
        low_len++;
      end
      if (!per_wr_n) chk(wait_req === 1'b1, "R3 strobe inside wait", wait_req, 1);
      if (!prev_per && per_wr_n) begin
        chk(low_len == W, "R3 strobe length", low_len, W);
        chk(prev_wait && !wait_req, "R4 end together", wait_req, 0);
        high_len = 1;
      end else if (per_wr_n && high_len < 1000) begin
        high_len++;
      end
      prev_per  = per_wr_n;
      prev_wait = wait_req;
    end
  end

  // processor model: enter and leave just after a falling edge
  task automatic cpu_write(input bit sel, input int extra, input int idle);
    int p0 = pulses;
    int wl = 0;
    cpu_wr_n = 1'b0;
    per_sel  = sel;
    @(negedge clk);
    if (sel) begin
      chk(wait_req === 1'b1, "R2 wait raised", wait_req, 1);
      while (wait_req === 1'b1 && wl < 100) begin
        wl++;
        @(negedge clk);
      end
      chk(wl >= W, "R3 wait length", wl, W);
      repeat (1 + extra) @(negedge clk);
    end else begin
      repeat (3) begin
        chk(wait_req === 1'b0 && per_wr_n === 1'b1, "R7 unselected quiet", {wait_req, per_wr_n}, 1);
        @(negedge clk);
      end
    end
    cpu_wr_n = 1'b1;
    @(negedge clk);
    repeat (idle) @(negedge clk);
    #1;
    chk((pulses - p0) == (sel ? 1 : 0), "R8 one strobe per write", pulses - p0, sel ? 1 : 0);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7321));
    repeat (3) @(negedge clk);
    chk(wait_req === 1'b0 && per_wr_n === 1'b1, "R1 reset levels", {wait_req, per_wr_n}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wait_req === 1'b0 && per_wr_n === 1'b1, "R1 after reset", {wait_req, per_wr_n}, 1);
    mon_on = 1'b1;

    cpu_write(1'b0, 0, 2);   // R7 unselected
    cpu_write(1'b1, 0, 8);   // R3/R4 isolated
    cpu_write(1'b1, 0, 0);   // R6 back-to-back byte pair
    cpu_write(1'b1, 0, 0);
    cpu_write(1'b1, 6, 8);   // R8 long hold
    cpu_write(1'b0, 0, 0);
    cpu_write(1'b1, 0, 0);

    for (int i = 0; i < 400; i++)
      cpu_write(($urandom % 4) != 0, $urandom % 4, $urandom % 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule